// File: doc/BRIEF.md
# Helicity Window History Recorder

This block follows the beam-state levels that the polarized source supplies: the helicity bit, the settle gate and the pair-sync marker. It records one entry per helicity window into a circular history memory. A window starts when the synchronized settle level falls. A short, fixed number of cycles later, all three levels are captured together into the entry at the write pointer. Windows last about 1 ms and may be as short as 0.5 ms, so the block needs no fast data path. It does need a clean boundary detector.

On an event trigger, the block streams its history out through a valid/ready port. The stream starts with one header word, followed by every stored entry from oldest to newest. Downstream logic merges these words into the event record next to the detector hits, so each event's helicity can be recovered offline.

The block also drives a delayed helicity level. It reports the helicity of the window that lies a configured number of patterns behind the newest one. A pattern is a pair, a quartet or an octet of windows, chosen by a setup input. A flag marks the delayed level as valid only once enough windows exist to reach that far back. The block also counts the windows that carry the pair-sync marker, which gives a running pattern number.

Top module: `helicity_history`

## Requirements
- R1: After reset, out_valid, dly_valid, dly_hel and pat_count are 0, and a trigger yields only a header reporting zero entries and pointer 0.
- R2: Each falling edge of the synchronized settle input records exactly one entry. The entry holds the synchronized helicity, pair-sync and settle levels sampled SAMPLE_LAG cycles after the edge. A settle bit of 1 therefore flags settle rising again inside that lag. A second falling edge inside the lag restarts the wait.
- R3: The write pointer advances by one per recorded entry and wraps modulo 2^AW. The stored-entry count saturates at 2^AW.
- R4: After an accepted trigger, the port emits a header word and then min(count, 2^AW) entry words, oldest to newest. Header: bit 2AW+1 = 1, bits 2AW:AW = entry count, bits AW-1:0 = write pointer. Entry word: bit 2AW+1 = 0, bits 2:0 = {settle, pair-sync, helicity}, all other bits 0.
- R5: A word presented with out_valid high stays unchanged until out_ready is high in the same cycle. Only then does the next word follow.
- R6: A trigger that arrives while a readout is in progress is ignored, so no extra words follow the readout in progress.
- R7: pat_sel selects the pattern length in windows: 0 = 2, 1 = 4, 2 or 3 = 8.
- R8: While dly_valid is high, dly_hel equals the helicity of the entry that lies delay_pat × pattern-length windows before the newest entry.
- R9: dly_valid is high exactly when more than delay_pat × pattern-length entries have been recorded and that product is below 2^AW. While dly_valid is low, dly_hel reads 0.
- R10: pat_count increments, wrapping modulo 2^PW, for every recorded entry whose pair-sync bit is 1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hel_in | input | 1 | Helicity level, asynchronous |
| settle_in | input | 1 | Settle gate, asynchronous; falling edge opens a window |
| psync_in | input | 1 | Pair-sync marker, asynchronous; high in the first window of a pattern |
| pat_sel | input | 2 | Pattern length select (setup) |
| delay_pat | input | DLY_W | Delay in patterns (setup) |
| trig | input | 1 | Event trigger, one-cycle pulse |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | Readout word present |
| out_data | output | 2*AW+2 | Header or entry word |
| dly_hel | output | 1 | Delayed helicity level |
| dly_valid | output | 1 | Delayed helicity valid |
| pat_count | output | PW | Count of windows carrying pair-sync |

## Verification
The bench sweeps every pattern select against delays that fall short of, exactly reach and exceed the history depth. It checks the delayed level and its valid flag after each window. An off-by-one in the tap address or the valid comparison would report a neighbouring window, or would raise the flag one window early. Runs longer than the memory force a wrap, where a pointer or saturation error would give a wrong header count or send the oldest entries out of order. Readouts stall out_ready in a repeating pattern and retrigger mid-stream, which catches a word that changes while stalled and a second header that is started by mistake. Windows with a brief settle re-assertion make sure the settle bit is sampled after the lag and not at the edge itself.

// File: rtl/hh_pkg.sv
package hh_pkg;

  typedef struct packed {
    logic settle;
    logic psync;
    logic hel;
  } hh_entry_t;

  typedef enum logic [1:0] {
    RO_IDLE  = 2'd0,
    RO_SEND  = 2'd1,
    RO_FETCH = 2'd2
  } ro_state_e;

  // windows per pattern for a select code
  function automatic logic [3:0] pat_len(input logic [1:0] sel);
    case (sel)
      2'd0:    pat_len = 4'd2;
      2'd1:    pat_len = 4'd4;
      default: pat_len = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/hh_edge_sampler.sv
module hh_edge_sampler import hh_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_LAG  = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hel_i,
  input  logic      settle_i,
  input  logic      psync_i,
  output logic      cap_o,
  output hh_entry_t entry_o
);
  localparam int LW = (SAMPLE_LAG > 1) ? $clog2(SAMPLE_LAG) : 1;

  logic [2:0] stage_q [SYNC_STAGES];

  // multi-flop synchronizer, one register row per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= {settle_i, psync_i, hel_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  hh_entry_t cur;
  assign cur = hh_entry_t'(stage_q[SYNC_STAGES-1]);

  logic          settle_prev_q;
  logic          armed_q;
  logic [LW-1:0] lag_q;
  logic          fall;

  assign fall = settle_prev_q & ~cur.settle;

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_prev_q <= 1'b0;
      armed_q       <= 1'b0;
      lag_q         <= '0;
    end else begin
      settle_prev_q <= cur.settle;
      if (fall) begin
        armed_q <= 1'b1;
        lag_q   <= LW'(SAMPLE_LAG - 1);
      end else if (armed_q && lag_q == '0) begin
        armed_q <= 1'b0;
      end else if (armed_q) begin
        lag_q <= lag_q - 1'b1;
      end
    end
  end

  assign cap_o   = armed_q && (lag_q == '0) && !fall;
  assign entry_o = cur;

endmodule

// File: rtl/hh_history.sv
module hh_history import hh_pkg::*; #(
  parameter int AW    = 8,
  parameter int DLY_W = 6,
  parameter int PW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  hh_entry_t        entry_i,
  input  logic [1:0]       pat_sel_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [AW-1:0]    rd_addr_i,
  output hh_entry_t        rd_data_o,
  output logic [AW-1:0]    wp_o,
  output logic [AW:0]      cnt_o,
  output logic             dly_hel_o,
  output logic             dly_valid_o,
  output logic [PW-1:0]    pat_cnt_o
);
  localparam int DEPTH = 1 << AW;
  localparam int PRW   = DLY_W + 4;
  localparam int CW    = (PRW > AW + 1) ? PRW : AW + 1;

  logic [AW-1:0]  wp_q;
  logic [AW:0]    cnt_q;
  logic [PW-1:0]  pat_q;
  logic           dvalid_q;
  logic           tap_bit_q;
  hh_entry_t      rd_q;

  logic [PRW-1:0] span;
  logic [AW-1:0]  tap;
  logic           reach_ok;

  assign span     = PRW'(delay_i) * PRW'(pat_len(pat_sel_i));
  assign tap      = wp_q - AW'(1) - span[AW-1:0];
  assign reach_ok = (CW'(span) < CW'(DEPTH)) && (CW'(cnt_q) > CW'(span));

  // entry store and helicity-only copy for the delay tap
  hh_entry_t mem     [DEPTH];
  logic      hel_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cap_i) begin
      mem[wp_q]     <= entry_i;
      hel_mem[wp_q] <= entry_i.hel;
    end
    rd_q      <= mem[rd_addr_i];
    tap_bit_q <= hel_mem[tap];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q     <= '0;
      cnt_q    <= '0;
      pat_q    <= '0;
      dvalid_q <= 1'b0;
    end else begin
      dvalid_q <= reach_ok;
      if (cap_i) begin
        wp_q <= wp_q + 1'b1;
        if (cnt_q != (AW+1)'(DEPTH)) cnt_q <= cnt_q + 1'b1;
        if (entry_i.psync) pat_q <= pat_q + 1'b1;
      end
    end
  end

  assign rd_data_o   = rd_q;
  assign wp_o        = wp_q;
  assign cnt_o       = cnt_q;
  assign dly_valid_o = dvalid_q;
  assign dly_hel_o   = tap_bit_q & dvalid_q;
  assign pat_cnt_o   = pat_q;

endmodule

// File: rtl/hh_readout.sv
module hh_readout import hh_pkg::*; #(
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_i,
  input  logic [AW-1:0]   wp_i,
  input  logic [AW:0]     cnt_i,
  input  hh_entry_t       rd_data_i,
  input  logic            ready_i,
  output logic [AW-1:0]   rd_addr_o,
  output logic            valid_o,
  output logic [2*AW+1:0] data_o,
  output logic            busy_o
);
  localparam int OW = 2 * AW + 2;

  ro_state_e         st_q;
  logic [AW:0]       left_q;
  logic [AW-1:0]     addr_q;
  logic              valid_q;
  logic [OW-1:0]     data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RO_IDLE;
      left_q  <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      case (st_q)
        RO_IDLE: begin
          if (trig_i) begin
            data_q  <= {1'b1, cnt_i, wp_i};
            valid_q <= 1'b1;
            left_q  <= cnt_i;
            addr_q  <= wp_i - cnt_i[AW-1:0];
            st_q    <= RO_SEND;
          end
        end
        RO_SEND: begin
          if (ready_i) begin
            valid_q <= 1'b0;
            st_q    <= (left_q == '0) ? RO_IDLE : RO_FETCH;
          end
        end
        RO_FETCH: begin
          // registered memory word for addr_q is ready here
          data_q  <= {1'b0, {(OW-4){1'b0}}, rd_data_i};
          valid_q <= 1'b1;
          addr_q  <= addr_q + 1'b1;
          left_q  <= left_q - 1'b1;
          st_q    <= RO_SEND;
        end
        default: st_q <= RO_IDLE;
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign busy_o    = (st_q != RO_IDLE);

endmodule

// File: rtl/helicity_history.sv
module helicity_history import hh_pkg::*; #(
  parameter int AW          = 8,
  parameter int DLY_W       = 6,
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_LAG  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hel_in,
  input  logic             settle_in,
  input  logic             psync_in,
  input  logic [1:0]       pat_sel,
  input  logic [DLY_W-1:0] delay_pat,
  input  logic             trig,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [2*AW+1:0]  out_data,
  output logic             dly_hel,
  output logic             dly_valid,
  output logic [PW-1:0]    pat_count
);
  logic          cap;
  hh_entry_t     smp_entry;
  hh_entry_t     rd_entry;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wp;
  logic [AW:0]   cnt;
  logic          busy;

  hh_edge_sampler #(
    .SYNC_STAGES(SYNC_STAGES),
    .SAMPLE_LAG (SAMPLE_LAG)
  ) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .hel_i   (hel_in),
    .settle_i(settle_in),
    .psync_i (psync_in),
    .cap_o   (cap),
    .entry_o (smp_entry)
  );

  hh_history #(
    .AW   (AW),
    .DLY_W(DLY_W),
    .PW   (PW)
  ) u_history (
    .clk        (clk),
    .rst        (rst),
    .cap_i      (cap),
    .entry_i    (smp_entry),
    .pat_sel_i  (pat_sel),
    .delay_i    (delay_pat),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_entry),
    .wp_o       (wp),
    .cnt_o      (cnt),
    .dly_hel_o  (dly_hel),
    .dly_valid_o(dly_valid),
    .pat_cnt_o  (pat_count)
  );

  hh_readout #(
    .AW(AW)
  ) u_readout (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig),
    .wp_i     (wp),
    .cnt_i    (cnt),
    .rd_data_i(rd_entry),
    .ready_i  (out_ready),
    .rd_addr_o(rd_addr),
    .valid_o  (out_valid),
    .data_o   (out_data),
    .busy_o   (busy)
  );

endmodule

// File: rtl/hh_checker.sv
module hh_checker import hh_pkg::*; #(
  parameter int AW    = 8,
  parameter int DLY_W = 6,
  parameter int PW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cap,
  input logic             cap_psync,
  input logic [AW-1:0]    wp,
  input logic             trig,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2*AW+1:0]  out_data,
  input logic [1:0]       pat_sel,
  input logic [DLY_W-1:0] delay_pat,
  input logic             dly_valid,
  input logic [PW-1:0]    pat_count
);
  localparam int DEPTH = 1 << AW;
  localparam int OW    = 2 * AW + 2;

  logic too_far;
  assign too_far = (int'(delay_pat) * int'(pat_len(pat_sel))) >= DEPTH;

  logic hdr_pending_q;
  always_ff @(posedge clk) begin
    if (rst)                         hdr_pending_q <= 1'b0;
    else if (trig && !busy)          hdr_pending_q <= 1'b1;
    else if (out_valid && out_ready) hdr_pending_q <= 1'b0;
  end

  a_r3_wp_advance: assert property (@(posedge clk) disable iff (rst)
    cap |=> wp == $past(wp) + 1'b1);

  a_r3_wp_hold: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(wp));

  a_r5_stall_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r4_header_first: assert property (@(posedge clk) disable iff (rst)
    hdr_pending_q && out_valid |-> out_data[OW-1]);

  a_r4_entry_tag: assert property (@(posedge clk) disable iff (rst)
    !hdr_pending_q && out_valid |-> !out_data[OW-1]);

  a_r9_out_of_reach: assert property (@(posedge clk) disable iff (rst)
    too_far |=> !dly_valid);

  a_r10_pat_step: assert property (@(posedge clk) disable iff (rst)
    cap && cap_psync |=> pat_count == $past(pat_count) + 1'b1);

  a_r10_pat_hold: assert property (@(posedge clk) disable iff (rst)
    !(cap && cap_psync) |=> $stable(pat_count));

endmodule

bind helicity_history hh_checker #(
  .AW   (AW),
  .DLY_W(DLY_W),
  .PW   (PW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cap      (cap),
  .cap_psync(smp_entry.psync),
  .wp       (wp),
  .trig     (trig),
  .busy     (busy),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .pat_sel  (pat_sel),
  .delay_pat(delay_pat),
  .dly_valid(dly_valid),
  .pat_count(pat_count)
);

// File: tb/helicity_history_test.sv
`timescale 1ns/1ps
module helicity_history_test;
  localparam int AW    = 4;
  localparam int DLY_W = 3;
  localparam int PW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int OW    = 2 * AW + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hel_in = 1'b0, settle_in = 1'b0, psync_in = 1'b0;
  logic [1:0]       pat_sel = 2'd0;
  logic [DLY_W-1:0] delay_pat = '0;
  logic             trig = 1'b0, out_ready = 1'b0;
  logic             out_valid, dly_hel, dly_valid;
  logic [OW-1:0]    out_data;
  logic [PW-1:0]    pat_count;

  helicity_history #(.AW(AW), .DLY_W(DLY_W), .PW(PW), .SYNC_STAGES(2), .SAMPLE_LAG(2)) uut (
    .clk(clk), .rst(rst), .hel_in(hel_in), .settle_in(settle_in), .psync_in(psync_in),
    .pat_sel(pat_sel), .delay_pat(delay_pat), .trig(trig), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .dly_hel(dly_hel), .dly_valid(dly_valid),
    .pat_count(pat_count));

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit hist_h [256];
  bit hist_p [256];
  bit hist_s [256];
  int nwin   = 0;
  int npsync = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; settle_in = 1'b0; hel_in = 1'b0; psync_in = 1'b0;
    trig = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nwin = 0; npsync = 0;
  endtask

  // one helicity window; glitch re-raises settle within the sample lag
  task automatic window(input bit h, input bit p, input bit g);
    @(negedge clk);
    hel_in = h; psync_in = p; settle_in = 1'b1;
    repeat (4) @(negedge clk);
    settle_in = 1'b0;
    if (g) begin
      @(negedge clk);
      settle_in = 1'b1;
    end
    repeat (8) @(negedge clk);
    hist_h[nwin] = h; hist_p[nwin] = p; hist_s[nwin] = g;
    nwin++;
    if (p) npsync++;
  endtask

  task automatic check_delay(input int plen, input int d);
    int  span;
    bit  ev;
    span = d * plen;
    ev   = (nwin > span) && (span < DEPTH);
    chk(dly_valid == ev, "R9 valid flag", int'(dly_valid), int'(ev));
    if (ev) chk(dly_hel == hist_h[nwin-1-span], "R7 R8 delayed helicity",
                int'(dly_hel), int'(hist_h[nwin-1-span]));
    else    chk(dly_hel == 1'b0, "R9 level while invalid", int'(dly_hel), 0);
    chk(int'(pat_count) == (npsync % (1 << PW)), "R10 pattern count",
        int'(pat_count), npsync % (1 << PW));
  endtask

  task automatic readout(input bit retrig);
    int ecnt, ewp, got, cyc, expw, idx;
    bit hold, extra;
    logic [OW-1:0] prevd;
    ecnt = (nwin < DEPTH) ? nwin : DEPTH;
    ewp  = nwin % DEPTH;
    got = 0; cyc = 0; hold = 1'b0; extra = 1'b0; prevd = '0;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    while (got < ecnt + 1 && cyc < 600) begin
      if (hold && out_valid)
        chk(out_data == prevd, "R5 stalled word stable", int'(out_data), int'(prevd));
      out_ready = ((cyc % 3) != 1);
      if (out_valid && out_ready) begin
        if (got == 0) begin
          expw = (1 << (OW-1)) | (ecnt << AW) | ewp;
          chk(int'(out_data) == expw, "R4 header word", int'(out_data), expw);
        end else begin
          idx  = nwin - ecnt + got - 1;
          expw = (int'(hist_s[idx]) << 2) | (int'(hist_p[idx]) << 1) | int'(hist_h[idx]);
          chk(int'(out_data) == expw, "R2 R4 entry word order", int'(out_data), expw);
        end
        got++;
      end
      hold  = out_valid && !out_ready;
      prevd = out_data;
      trig  = retrig && (got == 2);
      @(negedge clk);
      cyc++;
    end
    trig = 1'b0; out_ready = 1'b1;
    chk(got == ecnt + 1, "R4 word count", got, ecnt + 1);
    for (int k = 0; k < 12; k++) begin
      if (out_valid) extra = 1'b1;
      @(negedge clk);
    end
    chk(!extra, "R6 no words after readout", int'(extra), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(dly_valid == 1'b0, "R1 dly_valid after reset", int'(dly_valid), 0);
    chk(dly_hel == 1'b0, "R1 dly_hel after reset", int'(dly_hel), 0);
    chk(pat_count == '0, "R1 pat_count after reset", int'(pat_count), 0);
    readout(1'b0);

    for (int sel = 0; sel < 4; sel++) begin
      for (int di = 0; di < 5; di++) begin
        int d, plen, span, nw;
        d    = (di == 4) ? 7 : di;
        plen = (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
        span = d * plen;
        nw   = (span + 2 < 20) ? span + 2 : 20;
        if (nw < 3) nw = 3;
        pat_sel   = 2'(sel);
        delay_pat = DLY_W'(d);
        do_reset();
        for (int k = 0; k < nw; k++) begin
          window(((k * k + 3 * k + d + sel) % 5) < 2, (k % plen) == 0, (k % 4) == 3);
          check_delay(plen, d);
        end
        readout(1'b1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule